// File: doc/BRIEF.md
# Shared Cache Bank Controller with Atomic Line Locking

This block controls one bank of a shared last-level cache in a multicore system that has no directory and sends no invalidations. Cores send three kinds of request: a plain read, which returns the whole line at once; a word-masked write-through, which merges only the selected words into the line and is acknowledged; and an atomic read-modify-write fetch. The bank keeps no per-line sharing state. Its only coherence bookkeeping is a lock bit and an owner core ID for each line, and it uses these only for atomics.

An atomic fetch to an unlocked line returns the line and locks it for the requesting core. The line stays locked until that core sends a write-through to it. That write-through carries the updated value and releases the lock. A request from any other core to a locked line is parked in a single arrival-ordered queue. While the queue holds anything, every new request joins the back of it, so the bank serves requests in the order they arrived. The only exception is the owner's releasing write-through, which is always served on arrival. Once the line at the head of the queue is unlocked, parked requests are replayed one per cycle. A replayed atomic locks the line again, and the entries behind it wait for that new owner. The controller has two named states. PASS means the queue is empty and requests are served directly. STALL means the queue holds entries. The transition `park` (PASS to STALL) happens when a request is enqueued. The transition `drained` (STALL to PASS) happens when the last entry leaves and nothing new is enqueued in the same cycle. A cycle that neither parks nor drains keeps the current state.

Top module: `llc_lock_bank`

## Requirements
- R1: After reset the bank gives no response, every line reads as zero, no line is locked and the queue is empty.
- R2: A read (`req_op`=0) that is served in cycle t produces, in cycle t+1, `rsp_valid`=1, `rsp_kind`=0, `rsp_core`=requester and `rsp_data`=the current line.
- R3: A write-through (`req_op`=1) replaces word i of the line only where `req_wmask[i]`=1. Word i occupies bits [i*DATA_W +: DATA_W]. The write-through is acknowledged one cycle later with `rsp_kind`=1 and `rsp_data`=0.
- R4: A read served in the cycle right after a write-through to the same line returns the merged data, never the old data.
- R5: An atomic (`req_op`=2) on an unlocked line returns the line with `rsp_kind`=2, and it locks the line with the requester recorded as owner.
- R6: A read, write-through or atomic from a non-owner to a locked line gets no response and leaves the line's data unchanged until the lock is released.
- R7: A write-through from the owner of a locked line is served in the cycle it arrives, even when the queue is non-empty. It merges its words and releases the lock. When it arrives in the same cycle that a parked request could be replayed, it takes priority.
- R8: While the queue is non-empty, every new request other than an owner's releasing write-through is enqueued. Parked requests are replayed one per cycle, in arrival order, whenever the head's line is unlocked. The queue holds N_CORES entries.
- R9: A replayed atomic locks its line again before the next queue entry is considered, so entries behind it that target that line keep waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write-through, 2 atomic |
| req_core | input | CORE_W | Requesting core ID |
| req_line | input | LINE_W | Line index in the bank |
| req_wmask | input | WORDS | Per-word write enable for write-through |
| req_wdata | input | WORDS*DATA_W | Write-through data, word i at bits [i*DATA_W +: DATA_W] |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | Kind of request being answered (same codes as req_op) |
| rsp_core | output | CORE_W | Core that receives the response |
| rsp_data | output | WORDS*DATA_W | Line data for read and atomic, zero for write-through acknowledge |

## Verification
The assertions assume that each core has at most one request parked at a time. They also assume that a core holding a lock sends nothing except its releasing write-through until the lock is gone. Together these bound the queue by the core count and rule out a lock cycle between two owners. The random stimulus enforces both rules: a core with a parked request stays silent, and a lock owner may only emit its releasing write-through. Line indices are drawn from a small range so that locks, parking and replay happen often.

// File: rtl/llc_lock_pkg.sv
package llc_lock_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_WT   = 2'd1,
        OP_ATOM = 2'd2
    } op_e;

    typedef enum logic {
        ST_PASS  = 1'b0,
        ST_STALL = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/llc_req_fifo.sv
module llc_req_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= din;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign dout  = slots[rd_ptr];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && !pop && cnt_q == CNT_W'(DEPTH)));
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && cnt_q == '0));

endmodule

// File: rtl/llc_line_store.sv
module llc_line_store #(
    parameter int N_LINES = 16,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(N_LINES)-1:0] wr_line,
    input  logic [WORDS-1:0]          wr_mask,
    input  logic [WORDS*DATA_W-1:0]   wr_data,
    input  logic [$clog2(N_LINES)-1:0] rd_line,
    output logic [WORDS*DATA_W-1:0]   rd_data
);
    localparam int LINE_BITS = WORDS * DATA_W;

    logic [LINE_BITS-1:0] lines [N_LINES];
    logic [LINE_BITS-1:0] merged;

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign merged[w*DATA_W +: DATA_W] = wr_mask[w] ? wr_data[w*DATA_W +: DATA_W]
                                                           : lines[wr_line][w*DATA_W +: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINES; i++) lines[i] <= '0;
        end else if (wr_en) begin
            lines[wr_line] <= merged;
        end
    end

    assign rd_data = lines[rd_line];

endmodule

// File: rtl/llc_lock_table.sv
module llc_lock_table #(
    parameter int N_LINES = 16,
    parameter int N_CORES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_en,
    input  logic [$clog2(N_LINES)-1:0] set_line,
    input  logic [$clog2(N_CORES)-1:0] set_core,
    input  logic                       clr_en,
    input  logic [$clog2(N_LINES)-1:0] clr_line,
    input  logic [$clog2(N_LINES)-1:0] qa_line,
    input  logic [$clog2(N_CORES)-1:0] qa_core,
    output logic                       qa_locked,
    output logic                       qa_is_owner,
    input  logic [$clog2(N_LINES)-1:0] qb_line,
    output logic                       qb_locked,
    output logic [N_LINES-1:0]         locked_vec
);
    localparam int CORE_W = $clog2(N_CORES);

    logic [N_LINES-1:0] lock_q;
    logic [CORE_W-1:0]  owner_q [N_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
            for (int i = 0; i < N_LINES; i++) owner_q[i] <= '0;
        end else begin
            if (clr_en) lock_q[clr_line] <= 1'b0;
            if (set_en) begin
                lock_q[set_line]  <= 1'b1;
                owner_q[set_line] <= set_core;
            end
        end
    end

    assign qa_locked   = lock_q[qa_line];
    assign qa_is_owner = lock_q[qa_line] && (owner_q[qa_line] == qa_core);
    assign qb_locked   = lock_q[qb_line];
    assign locked_vec  = lock_q;

    assert_lock_free_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !lock_q[set_line]);
    assert_release_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> lock_q[clr_line]);
    assert_set_clear_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && clr_en));

endmodule

// File: rtl/llc_lock_bank.sv
module llc_lock_bank
    import llc_lock_pkg::*;
#(
    parameter int N_CORES = 16,
    parameter int N_LINES = 16,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [1:0]                  req_op,
    input  logic [$clog2(N_CORES)-1:0]  req_core,
    input  logic [$clog2(N_LINES)-1:0]  req_line,
    input  logic [WORDS-1:0]            req_wmask,
    input  logic [WORDS*DATA_W-1:0]     req_wdata,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_kind,
    output logic [$clog2(N_CORES)-1:0]  rsp_core,
    output logic [WORDS*DATA_W-1:0]     rsp_data
);
    localparam int CORE_W    = $clog2(N_CORES);
    localparam int LINE_W    = $clog2(N_LINES);
    localparam int LINE_BITS = WORDS * DATA_W;
    localparam int ENTRY_W   = 2 + CORE_W + LINE_W + WORDS + LINE_BITS;
    localparam int CNT_W     = $clog2(N_CORES+1);

    ctl_state_e state_q, state_d;

    logic [ENTRY_W-1:0] q_head;
    logic               q_empty;
    logic [CNT_W-1:0]   q_count;
    logic               q_push, q_pop;

    logic [1:0]           h_op;
    logic [CORE_W-1:0]    h_core;
    logic [LINE_W-1:0]    h_line;
    logic [WORDS-1:0]     h_mask;
    logic [LINE_BITS-1:0] h_data;
    assign {h_op, h_core, h_line, h_mask, h_data} = q_head;

    logic in_locked, in_owner, h_locked;
    logic [N_LINES-1:0] locked_vec;

    logic in_release, head_ok;
    assign in_release = req_valid && (op_e'(req_op) == OP_WT) && in_owner;
    assign head_ok    = !q_empty && !h_locked;

    logic srv_v, srv_head, srv_rel;
    logic [1:0]           srv_op;
    logic [CORE_W-1:0]    srv_core;
    logic [LINE_W-1:0]    srv_line;
    logic [WORDS-1:0]     srv_mask;
    logic [LINE_BITS-1:0] srv_wdata;
    logic [LINE_BITS-1:0] rd_data;

    // serve / park decision
    always_comb begin
        srv_v    = 1'b0;
        srv_head = 1'b0;
        srv_rel  = 1'b0;
        q_pop    = 1'b0;
        q_push   = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                if (in_release) begin
                    srv_v   = 1'b1;
                    srv_rel = 1'b1;
                end else if (req_valid) begin
                    if (!in_locked) srv_v  = 1'b1;
                    else            q_push = 1'b1;
                end
            end
            ST_STALL: begin
                if (in_release) begin
                    srv_v   = 1'b1;
                    srv_rel = 1'b1;
                end else if (head_ok) begin
                    srv_v    = 1'b1;
                    srv_head = 1'b1;
                    q_pop    = 1'b1;
                    q_push   = req_valid;
                end else begin
                    q_push = req_valid;
                end
            end
            default: ;
        endcase
    end

    assign srv_op    = srv_head ? h_op   : req_op;
    assign srv_core  = srv_head ? h_core : req_core;
    assign srv_line  = srv_head ? h_line : req_line;
    assign srv_mask  = srv_head ? h_mask : req_wmask;
    assign srv_wdata = srv_head ? h_data : req_wdata;

    // state transitions: park (PASS->STALL), drained (STALL->PASS)
    always_comb begin
        if (q_push || (q_count > CNT_W'(1)) || (q_count == CNT_W'(1) && !q_pop))
            state_d = ST_STALL;
        else
            state_d = ST_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PASS;
        else        state_q <= state_d;
    end

    llc_req_fifo #(.DEPTH(N_CORES), .WIDTH(ENTRY_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   ({req_op, req_core, req_line, req_wmask, req_wdata}),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .count (q_count)
    );

    llc_line_store #(.N_LINES(N_LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (srv_v && op_e'(srv_op) == OP_WT),
        .wr_line (srv_line),
        .wr_mask (srv_mask),
        .wr_data (srv_wdata),
        .rd_line (srv_line),
        .rd_data (rd_data)
    );

    llc_lock_table #(.N_LINES(N_LINES), .N_CORES(N_CORES)) u_locks (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (srv_v && op_e'(srv_op) == OP_ATOM),
        .set_line    (srv_line),
        .set_core    (srv_core),
        .clr_en      (srv_rel),
        .clr_line    (req_line),
        .qa_line     (req_line),
        .qa_core     (req_core),
        .qa_locked   (in_locked),
        .qa_is_owner (in_owner),
        .qb_line     (h_line),
        .qb_locked   (h_locked),
        .locked_vec  (locked_vec)
    );

    // response register
    logic [LINE_W-1:0] rsp_line_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= 2'd0;
            rsp_core   <= '0;
            rsp_data   <= '0;
            rsp_line_q <= '0;
        end else begin
            rsp_valid  <= srv_v;
            rsp_kind   <= srv_v ? srv_op : 2'd0;
            rsp_core   <= srv_v ? srv_core : '0;
            rsp_data   <= (srv_v && op_e'(srv_op) != OP_WT) ? rd_data : '0;
            rsp_line_q <= srv_line;
        end
    end

    assert_atomic_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && op_e'(rsp_kind) == OP_ATOM) |-> locked_vec[rsp_line_q]);
    assert_no_serve_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_v && !srv_rel) |-> !locked_vec[srv_line]);
    assert_pass_queue_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS) |-> q_empty);
    assert_order_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty && req_valid && !in_release) |-> q_push);

endmodule

// File: tb/llc_lock_bank_tb_top.sv
module llc_lock_bank_tb_top;
    localparam int NC = 16;
    localparam int NL = 16;
    localparam int NW = 4;
    localparam int DW = 32;
    localparam int CW = $clog2(NC);
    localparam int LW = $clog2(NL);
    localparam int LB = NW * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [CW-1:0] req_core = '0;
    logic [LW-1:0] req_line = '0;
    logic [NW-1:0] req_wmask = '0;
    logic [LB-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [CW-1:0] rsp_core;
    logic [LB-1:0] rsp_data;

    llc_lock_bank #(.N_CORES(NC), .N_LINES(NL), .WORDS(NW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_core(req_core), .req_line(req_line), .req_wmask(req_wmask),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_core(rsp_core), .rsp_data(rsp_data)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    typedef struct { int op; int core; int line; logic [NW-1:0] mask; logic [LB-1:0] data; } mreq_t;
    logic [LB-1:0] m_mem [NL];
    bit  m_lock [NL];
    int  m_owner [NL];
    mreq_t mq[$];
    bit  pend [NC];
    int  hold [NC];
    bit  e_v = 0;
    int  e_kind = 0, e_core = 0;
    logic [LB-1:0] e_data = '0;

    function automatic logic [LB-1:0] merge(logic [LB-1:0] old, logic [NW-1:0] m, logic [LB-1:0] d);
        logic [LB-1:0] r = old;
        for (int w = 0; w < NW; w++) if (m[w]) r[w*DW +: DW] = d[w*DW +: DW];
        return r;
    endfunction

    task automatic model_serve(mreq_t r, bit rel);
        e_v = 1; e_kind = r.op; e_core = r.core;
        e_data = (r.op == 1) ? '0 : m_mem[r.line];
        if (r.op == 1) m_mem[r.line] = merge(m_mem[r.line], r.mask, r.data);
        if (r.op == 2) begin m_lock[r.line] = 1; m_owner[r.line] = r.core; hold[r.core] = r.line; end
        if (rel) begin m_lock[r.line] = 0; hold[r.core] = -1; end
    endtask

    task automatic model_step(bit v, mreq_t r);
        bit rel = v && r.op == 1 && m_lock[r.line] && m_owner[r.line] == r.core;
        e_v = 0; e_kind = 0; e_core = 0; e_data = '0;
        if (rel) model_serve(r, 1);
        else if (mq.size() > 0 && !m_lock[mq[0].line]) begin
            mreq_t h = mq.pop_front();
            pend[h.core] = 0;
            model_serve(h, 0);
            if (v) begin mq.push_back(r); pend[r.core] = 1; end
        end else if (v) begin
            if (mq.size() == 0 && !m_lock[r.line]) model_serve(r, 0);
            else begin mq.push_back(r); pend[r.core] = 1; end
        end
    endtask

    task automatic compare();
        logic [1:0] ek = 2'(e_kind);
        logic [CW-1:0] ec = CW'(e_core);
        total++;
        if (rsp_valid !== e_v || (e_v && (rsp_kind !== ek || rsp_core !== ec || rsp_data !== e_data))) begin
            bad++;
            $display("FAIL %s: act v=%0d k=%0d c=%0d d=%h exp v=%0d k=%0d c=%0d d=%h",
                     tag, rsp_valid, rsp_kind, rsp_core, rsp_data, e_v, e_kind, e_core, e_data);
        end
    endtask

    // one cycle: check previous response, drive new request, advance model
    task automatic step(bit v, int op, int core, int line, logic [NW-1:0] m, logic [LB-1:0] d);
        mreq_t r;
        @(negedge clk);
        compare();
        r.op = op; r.core = core; r.line = line; r.mask = m; r.data = d;
        req_valid = v; req_op = 2'(op); req_core = CW'(core); req_line = LW'(line);
        req_wmask = m; req_wdata = d;
        model_step(v, r);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, '0, '0);
    endtask

    function automatic logic [LB-1:0] rnd_line();
        logic [LB-1:0] x;
        for (int w = 0; w < NW; w++) x[w*DW +: DW] = $urandom;
        return x;
    endfunction

    bit done = 0;
    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NL; i++) begin m_mem[i] = '0; m_lock[i] = 0; m_owner[i] = 0; end
        for (int c = 0; c < NC; c++) begin pend[c] = 0; hold[c] = -1; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state, then a read of an untouched line returns zero
        tag = "R1"; idle();
        step(1, 0, 3, 5, '0, '0);
        idle();
        // R2 / R3 / R4: read, masked write, back-to-back read of merged line
        tag = "R2"; step(1, 0, 1, 2, '0, '0);
        tag = "R3"; step(1, 1, 4, 1, 4'b0101, rnd_line());
        tag = "R4"; step(1, 0, 6, 1, '0, '0);
        tag = "R3"; step(1, 1, 9, 1, 4'b1010, rnd_line());
        tag = "R4"; step(1, 0, 2, 1, '0, '0);
        idle();
        // R5: atomic locks line 3 for core 2
        tag = "R5"; step(1, 2, 2, 3, '0, '0);
        // R6: non-owner read, write-through, atomic to line 3 are parked
        tag = "R6"; step(1, 0, 4, 3, '0, '0);
        step(1, 1, 5, 3, 4'b1111, rnd_line());
        step(1, 2, 6, 3, '0, '0);
        step(1, 0, 8, 3, '0, '0);
        // R8: request to a free line still queues behind
        tag = "R8"; step(1, 0, 7, 0, '0, '0);
        idle(); idle();
        // R7: owner release served at once; R8/R9 replay follows
        tag = "R7"; step(1, 1, 2, 3, 4'b0011, rnd_line());
        tag = "R9"; repeat (6) idle();
        tag = "R7"; step(1, 1, 6, 3, 4'b1100, rnd_line());
        tag = "R8"; repeat (5) idle();
        // R2-R9 mixed: constrained random traffic
        tag = "R8";
        for (int n = 0; n < 4000; n++) begin
            int c = $urandom_range(NC-1);
            if ($urandom_range(9) < 3 || pend[c]) idle();
            else if (hold[c] >= 0) begin
                if ($urandom_range(2) == 0) step(1, 1, c, hold[c], 4'($urandom), rnd_line());
                else idle();
            end else begin
                int k = $urandom_range(9);
                int op = (k < 4) ? 0 : (k < 7) ? 1 : 2;
                step(1, op, c, $urandom_range(3), 4'($urandom), rnd_line());
            end
        end
        // drain: release every held lock, let the queue empty
        for (int n = 0; n < 400; n++) begin
            int who = -1;
            for (int c = 0; c < NC; c++) if (hold[c] >= 0 && who < 0) who = c;
            if (who >= 0) step(1, 1, who, hold[who], '0, '0);
            else idle();
        end
        tag = "R8";
        total++;
        if (mq.size() != 0) begin
            bad++;
            $display("FAIL R8: act queue=%0d exp=0", mq.size());
        end
        // final read-back of contended lines
        tag = "R4";
        for (int l = 0; l < 4; l++) step(1, 0, l, l, '0, '0);
        idle(); idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule